// File: doc/BRIEF.md
# Link Bring-up Sequencer and Monitor

This block drives the controller-side steps that bring a serial link out of reset and into the trained state, then keeps watch over the trained link. On a start request it holds the controller core in reset with the PHY powered down, releases the core reset, and waits for the clock to settle. It then powers up the PHY, enables the reference clock, and pulses the endpoint reset (active-low) with a hold time and a recovery time. Finally it caps the link speed at the first generation and enables the link training state machine as the last step. It then waits, up to a timeout, for the debug status to report a trained link.

Once the link is up, the block watches for a speed-change attempt that has hung. The training state machine sits in the receiver-lock substate of recovery, unchanged for a full observation window, while the PHY reports no valid receive data. When this happens the block pulses one output that forces both the receiver data enable and the receiver PLL enable, then releases it. All delays are given in microseconds and turned into cycle counts from the clock frequency parameter.

Top module: `link_bringup_seq`

## Requirements
- R1: While reset is asserted and then in idle, `core_rst` and `phy_pwrdn` are 1, and `refclk_en`, `perst_n`, `ltssm_en`, `gen1_only`, `rx_ovrd`, `link_up` and `fail` are 0.
- R2: `start` is acted on only in idle, link-up or failed state, and restarts the sequence at once. Reset and powerdown are then held for RST_US worth of cycles. A `start` during the sequence is ignored.
- R3: `core_rst` falls first. `phy_pwrdn` stays 1 for SETTLE_US worth of cycles after that, and then `phy_pwrdn` falls and `refclk_en` rises in the same cycle.
- R4: `perst_n` stays 0 for PERST_LOW_US worth of cycles after the reference clock is enabled, then rises. No later step starts until PERST_WAIT_US worth of cycles have passed.
- R5: `gen1_only` rises one cycle before `ltssm_en`. `ltssm_en` is 0 during every earlier step.
- R6: The link counts as good only when `dbg_status` bit 4 is 1 and bit 29 is 0. While training, `link_up` rises in the cycle after the first good sample, and `ltssm_en` stays 1.
- R7: If no good sample is seen within LINK_TIMEOUT_US worth of cycles of training, `fail` rises and `ltssm_en` falls. Both stay so until the next `start`.
- R8: With the link up, suppose `ltssm_state` equals 6'h0D (receiver lock in recovery) and is unchanged for STEADY_US worth of cycles, and `rx_valid` is 0. Then `rx_ovrd` is 1 for exactly OVRD_US worth of cycles.
- R9: No override pulse occurs while `rx_valid` is 1 or while `ltssm_state` changes within the window. After a pulse the window starts again, so a condition that persists gives repeated pulses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin (or restart) the bring-up sequence |
| dbg_status | input | 32 | Link debug word; bit 4 link-up, bit 29 in-training |
| ltssm_state | input | 6 | Current training state machine state code |
| rx_valid | input | 1 | PHY receive-valid indication |
| core_rst | output | 1 | Controller core reset |
| phy_pwrdn | output | 1 | PHY powerdown |
| refclk_en | output | 1 | Reference clock enable |
| perst_n | output | 1 | Endpoint reset, active low |
| ltssm_en | output | 1 | Training state machine enable |
| gen1_only | output | 1 | Cap maximum link speed at first generation |
| rx_ovrd | output | 1 | Receiver data-enable and PLL-enable override pulse |
| link_up | output | 1 | Link trained and being monitored |
| fail | output | 1 | Training timed out |

## Verification
The assertions take for granted that `dbg_status` is a settled, synchronous value sampled on the clock. This matters because the rise of `link_up` is tied to the previous cycle's bits 4 and 29. The stimulus changes every input only at the falling clock edge and holds it for whole cycles. It drives the link-good bits from a fixed debug word, and moves `ltssm_state` in runs of known length, either longer or shorter than the observation window. This lets the reference model decide without ambiguity whether a stall window completes.

// File: rtl/link_bringup_seq.sv
module link_bringup_seq #(
  parameter int CLK_FREQ_HZ     = 100_000_000,
  parameter int RST_US          = 100,
  parameter int SETTLE_US       = 30_000,
  parameter int PERST_LOW_US    = 100,
  parameter int PERST_WAIT_US   = 20_000,
  parameter int LINK_TIMEOUT_US = 100_000,
  parameter int STEADY_US       = 2_000,
  parameter int OVRD_US         = 10,
  parameter logic [5:0] RCVR_LOCK = 6'h0D
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        start,
  input  logic [31:0] dbg_status,
  input  logic [5:0]  ltssm_state,
  input  logic        rx_valid,
  output logic        core_rst,
  output logic        phy_pwrdn,
  output logic        refclk_en,
  output logic        perst_n,
  output logic        ltssm_en,
  output logic        gen1_only,
  output logic        rx_ovrd,
  output logic        link_up,
  output logic        fail
);
  localparam int CPU    = CLK_FREQ_HZ / 1_000_000;
  localparam int C_RST  = (CPU * RST_US) < 1 ? 1 : CPU * RST_US;
  localparam int C_SET  = (CPU * SETTLE_US) < 1 ? 1 : CPU * SETTLE_US;
  localparam int C_PLOW = (CPU * PERST_LOW_US) < 1 ? 1 : CPU * PERST_LOW_US;
  localparam int C_PWT  = (CPU * PERST_WAIT_US) < 1 ? 1 : CPU * PERST_WAIT_US;
  localparam int C_TO   = (CPU * LINK_TIMEOUT_US) < 1 ? 1 : CPU * LINK_TIMEOUT_US;
  localparam int C_STDY = (CPU * STEADY_US) < 1 ? 1 : CPU * STEADY_US;
  localparam int C_OVR  = (CPU * OVRD_US) < 1 ? 1 : CPU * OVRD_US;

  typedef enum logic [3:0] {
    S_IDLE, S_RST, S_SETTLE, S_PWRUP, S_PWAIT, S_CFG, S_TRAIN, S_UP, S_FAIL
  } st_t;

  st_t         st;
  logic [31:0] cnt, lim, steady, ovr_cnt;
  logic [5:0]  prev_ltssm;

  wire link_good = dbg_status[4] & ~dbg_status[29];
  wire unused_dbg = ^{dbg_status[31:30], dbg_status[28:5], dbg_status[3:0]};
  wire can_start = (st == S_IDLE) || (st == S_UP) || (st == S_FAIL);
  wire stuck = (ltssm_state == RCVR_LOCK) && !rx_valid;

  always_comb begin
    case (st)
      S_RST:    lim = 32'(C_RST);
      S_SETTLE: lim = 32'(C_SET);
      S_PWRUP:  lim = 32'(C_PLOW);
      S_PWAIT:  lim = 32'(C_PWT);
      S_TRAIN:  lim = 32'(C_TO);
      default:  lim = 32'd1;
    endcase
  end

  wire done = (cnt == lim - 32'd1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st  <= S_IDLE;
      cnt <= '0;
    end else if (start && can_start) begin
      st  <= S_RST;
      cnt <= '0;
    end else begin
      cnt <= cnt + 32'd1;
      case (st)
        S_RST:    if (done) begin st <= S_SETTLE; cnt <= '0; end
        S_SETTLE: if (done) begin st <= S_PWRUP;  cnt <= '0; end
        S_PWRUP:  if (done) begin st <= S_PWAIT;  cnt <= '0; end
        S_PWAIT:  if (done) begin st <= S_CFG;    cnt <= '0; end
        S_CFG:    begin st <= S_TRAIN; cnt <= '0; end
        S_TRAIN:  if (link_good) begin st <= S_UP; cnt <= '0; end
                  else if (done) begin st <= S_FAIL; cnt <= '0; end
        default:  cnt <= '0;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_ltssm <= '0;
      steady     <= '0;
      ovr_cnt    <= '0;
    end else begin
      prev_ltssm <= ltssm_state;
      if (st != S_UP || (start && can_start)) begin
        steady  <= '0;
        ovr_cnt <= '0;
      end else if (ovr_cnt != 0) begin
        ovr_cnt <= ovr_cnt - 32'd1;
        steady  <= '0;
      end else if (ltssm_state != prev_ltssm) begin
        steady <= '0;
      end else if (steady == 32'(C_STDY)) begin
        if (stuck) begin
          ovr_cnt <= 32'(C_OVR);
          steady  <= '0;
        end
      end else begin
        steady <= steady + 32'd1;
      end
    end
  end

  assign core_rst  = (st == S_IDLE) || (st == S_RST);
  assign phy_pwrdn = core_rst || (st == S_SETTLE);
  assign refclk_en = !phy_pwrdn;
  assign perst_n   = refclk_en && (st != S_PWRUP);
  assign gen1_only = (st == S_CFG) || (st == S_TRAIN) || (st == S_UP) || (st == S_FAIL);
  assign ltssm_en  = (st == S_TRAIN) || (st == S_UP);
  assign link_up   = (st == S_UP);
  assign fail      = (st == S_FAIL);
  assign rx_ovrd   = (ovr_cnt != 0);
endmodule

// File: rtl/link_bringup_seq_chk.sv
module link_bringup_seq_chk (
  input logic        clk,
  input logic        rst_n,
  input logic [31:0] dbg_status,
  input logic        core_rst,
  input logic        phy_pwrdn,
  input logic        refclk_en,
  input logic        perst_n,
  input logic        ltssm_en,
  input logic        gen1_only,
  input logic        rx_ovrd,
  input logic        link_up,
  input logic        fail
);
  AST_RST_BEFORE_PD: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(core_rst) |-> phy_pwrdn); // R3
  AST_PD_WITH_REF: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(phy_pwrdn) |-> $rose(refclk_en)); // R3
  AST_TRAIN_AFTER_PERST: assert property (@(posedge clk) disable iff (!rst_n)
    ltssm_en |-> perst_n && refclk_en && !core_rst); // R4
  AST_GEN1_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ltssm_en) |-> gen1_only && $past(gen1_only)); // R5
  AST_UP_ON_GOOD: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(link_up) |-> $past(dbg_status[4] && !dbg_status[29])); // R6
  AST_FAIL_STOPS: assert property (@(posedge clk) disable iff (!rst_n)
    fail |-> !ltssm_en && !link_up); // R7
  AST_OVRD_IN_UP: assert property (@(posedge clk) disable iff (!rst_n)
    rx_ovrd |-> link_up); // R8
endmodule

bind link_bringup_seq link_bringup_seq_chk u_chk (
  .clk(clk), .rst_n(rst_n), .dbg_status(dbg_status), .core_rst(core_rst),
  .phy_pwrdn(phy_pwrdn), .refclk_en(refclk_en), .perst_n(perst_n),
  .ltssm_en(ltssm_en), .gen1_only(gen1_only), .rx_ovrd(rx_ovrd),
  .link_up(link_up), .fail(fail)
);

// File: tb/link_bringup_seq_bench.sv
`timescale 1ns/1ps
module link_bringup_seq_bench;
  localparam int N_RST = 3, N_SET = 10, N_PLOW = 4, N_PWT = 8, N_TO = 30, N_STDY = 6, N_OVR = 3;

  logic clk = 0, rst_n = 0, start = 0, rx_valid = 1;
  logic [31:0] dbg_status = 0;
  logic [5:0] ltssm_state = 0;
  logic core_rst, phy_pwrdn, refclk_en, perst_n, ltssm_en, gen1_only, rx_ovrd, link_up, fail;
  int total = 0, bad = 0, cycles = 0;

  always #2.5 clk = ~clk;

  link_bringup_seq #(
    .CLK_FREQ_HZ(1_000_000), .RST_US(N_RST), .SETTLE_US(N_SET), .PERST_LOW_US(N_PLOW),
    .PERST_WAIT_US(N_PWT), .LINK_TIMEOUT_US(N_TO), .STEADY_US(N_STDY), .OVRD_US(N_OVR)
  ) u_link_bringup_seq (.*);

  // reference model: phases 0 idle,1 rst,2 settle,3 pwrup,4 pwait,5 cfg,6 train,7 up,8 fail
  int m_ph = 0, m_rem = 0, m_run = 0, m_ov = 0;
  logic [5:0] m_prev = 0;

  task automatic enter(input int ph, input int n);
    m_ph = ph; m_rem = n;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (!rst_n) begin
      m_ph = 0; m_rem = 0; m_run = 0; m_ov = 0; m_prev = 0;
    end else begin
      bit restart, good;
      restart = start && (m_ph == 0 || m_ph == 7 || m_ph == 8);
      good = dbg_status[4] && !dbg_status[29];
      if (restart || m_ph != 7) begin m_run = 0; m_ov = 0; end
      else if (m_ov > 0) begin m_ov--; m_run = 0; end
      else if (ltssm_state != m_prev) m_run = 0;
      else if (m_run >= N_STDY) begin
        if (ltssm_state == 6'h0D && !rx_valid) begin m_ov = N_OVR; m_run = 0; end
      end else m_run++;
      m_prev = ltssm_state;
      if (restart) enter(1, N_RST);
      else case (m_ph)
        1: if (m_rem == 1) enter(2, N_SET); else m_rem--;
        2: if (m_rem == 1) enter(3, N_PLOW); else m_rem--;
        3: if (m_rem == 1) enter(4, N_PWT); else m_rem--;
        4: if (m_rem == 1) enter(5, 1); else m_rem--;
        5: enter(6, N_TO);
        6: if (good) enter(7, 0); else if (m_rem == 1) enter(8, 0); else m_rem--;
        default: ;
      endcase
    end
  end

  task automatic chk(input string req, input string what, input logic act, input logic exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s actual=%0b expected=%0b at cycle %0d", req, what, act, exp, cycles);
    end
  endtask

  task automatic chk_int(input string req, input string what, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  always @(negedge clk) begin
    chk("R3", "core_rst",  core_rst,  m_ph <= 1);
    chk("R3", "phy_pwrdn", phy_pwrdn, m_ph <= 2);
    chk("R3", "refclk_en", refclk_en, m_ph >= 3);
    chk("R4", "perst_n",   perst_n,   m_ph >= 4);
    chk("R5", "gen1_only", gen1_only, m_ph >= 5);
    chk("R5", "ltssm_en",  ltssm_en,  m_ph == 6 || m_ph == 7);
    chk("R6", "link_up",   link_up,   m_ph == 7);
    chk("R7", "fail",      fail,      m_ph == 8);
    chk("R8", "rx_ovrd",   rx_ovrd,   m_ov > 0);
  end

  task automatic finish_run;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    bad++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    int n, t_rf, t_ref, t_pr, t_lt, rises, plen;
    bit g_prev, o_prev;
    repeat (3) @(negedge clk);
    // R1: outputs during reset
    chk("R1", "reset core_rst", core_rst, 1);
    chk("R1", "reset ltssm_en", ltssm_en, 0);
    chk("R1", "reset perst_n", perst_n, 0);
    rst_n = 1;
    repeat (3) @(negedge clk);
    chk("R1", "idle refclk_en", refclk_en, 0);

    // R2/R7: start with no link, stray start mid-sequence, timeout
    start = 1; n = 0;
    do begin
      @(negedge clk); n++;
      start = (n == 6);
    end while (!fail && n < 200);
    start = 0;
    chk_int("R7", "cycles to fail (R2 stray start ignored)", n, 1 + N_RST + N_SET + N_PLOW + N_PWT + 1 + N_TO);
    repeat (5) @(negedge clk);
    chk("R7", "fail held", fail, 1);
    chk("R7", "ltssm_en off in fail", ltssm_en, 0);

    // R3/R4/R5/R6: restart from fail, link bit with in-training set
    dbg_status = 32'h2000_0010;
    start = 1; n = 0; t_rf = 0; t_ref = 0; t_pr = 0; t_lt = 0; g_prev = 0;
    do begin
      g_prev = gen1_only;
      @(negedge clk); n++; start = 0;
      if (!core_rst && t_rf == 0) t_rf = n;
      if (refclk_en && t_ref == 0) t_ref = n;
      if (perst_n && t_pr == 0) t_pr = n;
      if (ltssm_en && t_lt == 0) begin t_lt = n; chk("R5", "gen1_only before ltssm_en", g_prev, 1); end
    end while (!ltssm_en && n < 200);
    chk_int("R2", "core reset release cycle", t_rf, 1 + N_RST);
    chk_int("R3", "refclk enable cycle", t_ref, 1 + N_RST + N_SET);
    chk_int("R4", "perst release cycle", t_pr, 1 + N_RST + N_SET + N_PLOW);
    chk_int("R5", "ltssm enable cycle", t_lt, 1 + N_RST + N_SET + N_PLOW + N_PWT + 1);
    repeat (5) @(negedge clk);
    chk("R6", "no link_up while in training", link_up, 0);
    dbg_status = 32'h0000_0010;
    @(negedge clk);
    chk("R6", "link_up after good sample", link_up, 1);
    chk("R6", "ltssm_en stays", ltssm_en, 1);

    // R9: receiver-lock but rx_valid high
    ltssm_state = 6'h0D; rx_valid = 1; rises = 0;
    repeat (20) begin @(negedge clk); if (rx_ovrd) rises++; end
    chk_int("R9", "override cycles with rx_valid=1", rises, 0);

    // R8/R9: stuck condition, repeated pulses
    rx_valid = 0; rises = 0; plen = 0; o_prev = 0;
    repeat (30) begin
      @(negedge clk);
      if (rx_ovrd && !o_prev) rises++;
      if (rx_ovrd && rises == 1) plen++;
      o_prev = rx_ovrd;
    end
    chk_int("R8", "first override pulse length", plen, N_OVR);
    chk_int("R9", "override pulse repeats", rises >= 2 ? 1 : 0, 1);

    // R9: state changes faster than the window
    rises = 0;
    for (int i = 0; i < 40; i++) begin
      ltssm_state = ((i / 3) % 2 == 0) ? 6'h0C : 6'h0D;
      @(negedge clk);
      if (i >= 5 && rx_ovrd) rises++;
    end
    chk_int("R9", "override cycles with changing state", rises, 0);

    // R2: start from link-up restarts
    start = 1;
    @(negedge clk); start = 0;
    chk("R2", "restart core_rst", core_rst, 1);
    chk("R2", "restart link_up", link_up, 0);
    repeat (3) @(negedge clk);
    finish_run();
  end
endmodule